// File: doc/BRIEF.md
# Constant-Fraction Timing Pick-off

This block watches a stream of unsigned pulse samples and marks one instant per pulse. That instant does not move with the pulse's amplitude. A peak holder keeps the largest sample seen since the last clear request. A small two-state discriminator compares each sample against fractions of that held peak. A signed trim is added to the peak before the fractions are taken. The discriminator arms near the start of a pulse. When the trailing edge falls below half of the trimmed peak, it disarms and emits a one-cycle time mark. A short fixed-width gate pulse follows each mark and feeds downstream gating logic.

The samples are taken to be the positive lobe of a unipolar or bipolar pulse. Anything below baseline arrives as zero. The held peak is not dropped by the mark. It stays until the surrounding reset logic raises `peak_clear`. All fraction arithmetic uses shifts, so the block has no dividers or multipliers. Outputs are registered: a sample presented before a rising clock edge shows its effect on the outputs just after that edge.

Top module: `cf_pickoff`

## Requirements
- R1: After reset, `held_peak` is 0 and `cf_armed`, `cf_mark` and `gate_pulse` are all 0.
- R2: On a cycle with `smp_valid` high and `peak_clear` low, `held_peak` becomes the larger of its old value and `smp_data`. A cycle with `smp_valid` low changes neither `held_peak` nor `cf_armed` and produces no mark, whatever `smp_data` holds.
- R3: A cycle with `peak_clear` high leaves `held_peak` at 0 and `cf_armed` at 0 after the edge. This holds even when a valid sample is present in that cycle, and that sample is discarded.
- R4: Let P be the peak including the current valid sample x, and E the trimmed level. When disarmed, the block arms after the edge if floor(x/2) > floor(E/4) + ARM_MARGIN.
- R5: When armed, a valid sample x with x < floor(E/2) raises `cf_mark` for exactly one cycle and drops `cf_armed` at the same edge. A sample equal to floor(E/2) does not mark.
- R6: With the default margin of 4, a zero held peak and zero trim, samples of 17 or less never arm the block. A sample of 18 arms it.
- R7: E is P plus the signed `trim_offset`, clamped to the range 0 to 2^DW-1. Because of the clamp, a negative sum gives E = 0, which can never mark. A sum above the top code uses the top code.
- R8: `gate_pulse` is high in the cycle of `cf_mark` and for GATE_LEN cycles in total. A new mark during the gate restarts the full count.
- R9: `held_peak` is unchanged by the mark and keeps its value after the pulse until `peak_clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Qualifies `smp_data` in this cycle |
| smp_data | input | DW (12) | Unsigned pulse sample |
| trim_offset | input | TW (8) | Signed trim added to the held peak before the fractions |
| peak_clear | input | 1 | Request from reset logic: empty the peak and disarm |
| held_peak | output | DW (12) | Peak held since the last clear |
| cf_armed | output | 1 | Discriminator is armed |
| cf_mark | output | 1 | One-cycle time mark on the trailing-edge crossing |
| gate_pulse | output | 1 | Fixed-width pulse that starts with each mark |

## Verification
A wrong held peak appears on `held_peak` right after the edge that took the sample. One cycle later it also shifts both the arming sample and the marking sample, so a peak error moves `cf_mark` by at least one sample. A stuck or wrongly entered armed state shows on `cf_armed` at once. It then shows as a missing mark or a mark with no arming before it on the next falling sample. The gate counter is visible only through `gate_pulse`, so a reload or decrement fault shows as a wrong gate length within GATE_LEN cycles of a mark. Pulses with two close marks are needed to expose a reload fault.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

  typedef enum logic {
    DISC_IDLE  = 1'b0,
    DISC_ARMED = 1'b1
  } disc_state_e;

  // Peak plus signed trim, clamped into [0, top].
  function automatic int trimmed_level(input int pk, input int trim, input int top);
    int s;
    s = pk + trim;
    if (s < 0) s = 0;
    else if (s > top) s = top;
    return s;
  endfunction

  // Onset test: half the sample above a quarter of the level plus margin.
  function automatic logic onset_hit(input int x, input int lvl, input int margin);
    return (x >> 1) > ((lvl >> 2) + margin);
  endfunction

  // Trailing-edge test: sample strictly below half the level.
  function automatic logic fall_hit(input int x, input int lvl);
    return x < (lvl >> 1);
  endfunction

endpackage

// File: rtl/cfp_peak_hold.sv
module cfp_peak_hold #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic          peak_clear,
  output logic [DW-1:0] peak_q,
  output logic [DW-1:0] peak_next
);

  logic pk_grow;

  assign pk_grow   = smp_valid && !peak_clear && (smp_data > peak_q);
  assign peak_next = peak_clear ? '0 : (pk_grow ? smp_data : peak_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          peak_q <= '0;
    else if (peak_clear) peak_q <= '0;
    else if (pk_grow)    peak_q <= smp_data;
  end

  AST_PEAK_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !peak_clear |=> peak_q >= $past(peak_q)); // R9

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    peak_clear |=> peak_q == '0); // R3

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !peak_clear) |=> $stable(peak_q)); // R2

endmodule

// File: rtl/cfp_level_trim.sv
module cfp_level_trim #(
  parameter int DW = 12,
  parameter int TW = 8
) (
  input  logic [DW-1:0]        peak_in,
  input  logic signed [TW-1:0] trim_offset,
  output logic [DW-1:0]        level
);

  localparam int TOP = (1 << DW) - 1;

  assign level = DW'(cfp_pkg::trimmed_level(int'(peak_in), int'(trim_offset), TOP));

endmodule

// File: rtl/cfp_disc.sv
module cfp_disc #(
  parameter int DW         = 12,
  parameter int ARM_MARGIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  input  logic [DW-1:0] level,
  input  logic          peak_clear,
  output logic          armed,
  output logic          fire,
  output logic          mark_q
);

  import cfp_pkg::*;

  disc_state_e st_q, st_d;
  logic        arm_ev;

  always_comb begin
    arm_ev = 1'b0;
    fire   = 1'b0;
    if (smp_valid && !peak_clear) begin
      if (st_q == DISC_IDLE) arm_ev = onset_hit(int'(smp_data), int'(level), ARM_MARGIN);
      else                   fire   = fall_hit(int'(smp_data), int'(level));
    end
  end

  always_comb begin
    st_d = st_q;
    if (peak_clear)  st_d = DISC_IDLE;
    else if (arm_ev) st_d = DISC_ARMED;
    else if (fire)   st_d = DISC_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= DISC_IDLE;
      mark_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      mark_q <= fire;
    end
  end

  assign armed = (st_q == DISC_ARMED);

  AST_MARK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mark_q |=> !mark_q); // R5

  AST_MARK_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    mark_q |-> (!armed && $past(armed))); // R5

  AST_ARM_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(smp_valid) && !$past(peak_clear))); // R4

  AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    peak_clear |=> !armed); // R3

endmodule

// File: rtl/cfp_gate_stretch.sv
module cfp_gate_stretch #(
  parameter int GATE_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic gate
);

  generate
    if (GATE_LEN <= 1) begin : g_single
      logic gate_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= fire;
      end
      assign gate = gate_q;
    end else begin : g_count
      localparam int GW = $clog2(GATE_LEN + 1);
      logic [GW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (fire)         cnt_q <= GW'(GATE_LEN);
        else if (cnt_q != '0)  cnt_q <= cnt_q - GW'(1);
      end
      assign gate = (cnt_q != '0);

      AST_GATE_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> cnt_q == GW'(GATE_LEN)); // R8

      AST_GATE_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && cnt_q != '0) |=> cnt_q == $past(cnt_q) - GW'(1)); // R8
    end
  endgenerate

endmodule

// File: rtl/cf_pickoff.sv
module cf_pickoff #(
  parameter int DW         = 12,
  parameter int TW         = 8,
  parameter int ARM_MARGIN = 4,
  parameter int GATE_LEN   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_valid,
  input  logic [DW-1:0]        smp_data,
  input  logic signed [TW-1:0] trim_offset,
  input  logic                 peak_clear,
  output logic [DW-1:0]        held_peak,
  output logic                 cf_armed,
  output logic                 cf_mark,
  output logic                 gate_pulse
);

  logic [DW-1:0] peak_next;
  logic [DW-1:0] eff_level;
  logic          disc_fire;

  cfp_peak_hold #(.DW(DW)) u_peak (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .peak_clear(peak_clear),
    .peak_q    (held_peak),
    .peak_next (peak_next)
  );

  cfp_level_trim #(.DW(DW), .TW(TW)) u_trim (
    .peak_in    (peak_next),
    .trim_offset(trim_offset),
    .level      (eff_level)
  );

  cfp_disc #(.DW(DW), .ARM_MARGIN(ARM_MARGIN)) u_disc (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_valid (smp_valid),
    .smp_data  (smp_data),
    .level     (eff_level),
    .peak_clear(peak_clear),
    .armed     (cf_armed),
    .fire      (disc_fire),
    .mark_q    (cf_mark)
  );

  cfp_gate_stretch #(.GATE_LEN(GATE_LEN)) u_gate (
    .clk  (clk),
    .rst_n(rst_n),
    .fire (disc_fire),
    .gate (gate_pulse)
  );

  AST_GATE_COVERS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    cf_mark |-> gate_pulse); // R8

  AST_MARK_PEAK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    cf_mark |-> $stable(held_peak)); // R9

endmodule

// File: tb/cf_pickoff_bench.sv
module cf_pickoff_bench;

  localparam int DW     = 12;
  localparam int TW     = 8;
  localparam int MARGIN = 4;
  localparam int GLEN   = 3;
  localparam int TOPV   = (1 << DW) - 1;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 smp_valid = 1'b0;
  logic [DW-1:0]        smp_data = '0;
  logic signed [TW-1:0] trim_offset = '0;
  logic                 peak_clear = 1'b0;
  logic [DW-1:0]        held_peak;
  logic                 cf_armed, cf_mark, gate_pulse;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  int m_pk = 0, m_arm = 0, m_mark = 0, m_g = 0, m_trim = 0;

  always #10 clk = ~clk; // 50 MHz

  cf_pickoff #(.DW(DW), .TW(TW), .ARM_MARGIN(MARGIN), .GATE_LEN(GLEN)) u_cf_pickoff (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .trim_offset(trim_offset), .peak_clear(peak_clear), .held_peak(held_peak),
    .cf_armed(cf_armed), .cf_mark(cf_mark), .gate_pulse(gate_pulse)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic set_trim(input int t);
    m_trim = t;
    trim_offset = TW'(t);
  endtask

  // One clock with model update and full port comparison.
  task automatic tick(input int v, input int d, input int clr);
    int e;
    int f;
    @(negedge clk);
    smp_valid = v[0]; smp_data = DW'(d); peak_clear = clr[0];
    f = 0;
    if (clr != 0) begin
      m_pk = 0; m_arm = 0;
    end else if (v != 0) begin
      if (d > m_pk) m_pk = d;
      e = m_pk + m_trim;
      if (e < 0) e = 0;
      if (e > TOPV) e = TOPV;
      if (m_arm == 0) begin
        if ((d / 2) > (e / 4) + MARGIN) m_arm = 1;
      end else if (d < e / 2) begin
        m_arm = 0; f = 1;
      end
    end
    if (f != 0) m_g = GLEN;
    else if (m_g > 0) m_g--;
    m_mark = f;
    @(posedge clk); #2;
    chk("R2 held_peak", int'(held_peak), m_pk);
    chk("R4 cf_armed", int'(cf_armed), m_arm);
    chk("R5 cf_mark", int'(cf_mark), m_mark);
    chk("R8 gate_pulse", int'(gate_pulse), (m_g > 0) ? 1 : 0);
  endtask

  task automatic t_reset;
    chk("R1 peak after reset", int'(held_peak), 0);
    chk("R1 armed after reset", int'(cf_armed), 0);
    chk("R1 mark after reset", int'(cf_mark), 0);
    chk("R1 gate after reset", int'(gate_pulse), 0);
  endtask

  task automatic t_basic_pulse;
    int gcount;
    set_trim(0);
    tick(1, 0, 1);
    tick(1, 100, 0);
    chk("R4 arms at onset", int'(cf_armed), 1);
    tick(1, 400, 0); tick(1, 800, 0); tick(1, 1000, 0);
    tick(1, 900, 0); tick(1, 700, 0);
    tick(1, 500, 0);
    chk("R5 equal half does not mark", int'(cf_mark), 0);
    tick(1, 499, 0);
    chk("R5 mark below half", int'(cf_mark), 1);
    chk("R5 disarm with mark", int'(cf_armed), 0);
    chk("R8 gate with mark", int'(gate_pulse), 1);
    gcount = 1;
    for (int i = 0; i < 6; i++) begin
      tick(1, 0, 0);
      if (gate_pulse) gcount++;
    end
    chk("R8 gate length", gcount, GLEN);
    chk("R9 peak kept after mark", int'(held_peak), 1000);
  endtask

  task automatic t_clear;
    tick(1, 0, 1);
    chk("R3 clear empties peak", int'(held_peak), 0);
    tick(1, 2000, 0);
    chk("R3 armed before clear", int'(cf_armed), 1);
    tick(1, 3000, 1);
    chk("R3 clear beats sample peak", int'(held_peak), 0);
    chk("R3 clear disarms", int'(cf_armed), 0);
    chk("R3 clear gives no mark", int'(cf_mark), 0);
  endtask

  task automatic t_noise;
    set_trim(0);
    tick(1, 0, 1);
    for (int i = 0; i < 3; i++) begin
      tick(1, 17, 0);
      chk("R6 noise stays disarmed", int'(cf_armed), 0);
    end
    tick(1, 18, 0);
    chk("R6 eighteen arms", int'(cf_armed), 1);
  endtask

  task automatic t_invalid;
    tick(0, 4095, 0);
    chk("R2 invalid keeps peak", int'(held_peak), 18);
    chk("R2 invalid keeps armed", int'(cf_armed), 1);
    tick(0, 0, 0);
    chk("R2 invalid low gives no mark", int'(cf_mark), 0);
    chk("R2 invalid low keeps armed", int'(cf_armed), 1);
  endtask

  task automatic t_trim;
    tick(1, 0, 1);
    set_trim(100);
    tick(1, 1000, 0);
    tick(1, 540, 0);
    chk("R7 positive trim raises crossing", int'(cf_mark), 1);
    tick(1, 0, 1);
    set_trim(-100);
    tick(1, 50, 0);
    chk("R7 zero level arms", int'(cf_armed), 1);
    tick(1, 0, 0);
    chk("R7 zero level never marks", int'(cf_mark), 0);
    chk("R7 zero level stays armed", int'(cf_armed), 1);
    tick(1, 0, 1);
    set_trim(127);
    tick(1, 4095, 0);
    tick(1, 2047, 0);
    chk("R7 top clamp no mark at 2047", int'(cf_mark), 0);
    tick(1, 2046, 0);
    chk("R7 top clamp mark at 2046", int'(cf_mark), 1);
    set_trim(0);
  endtask

  task automatic t_retrigger;
    int gcount;
    tick(1, 0, 1);
    tick(1, 1000, 0);
    tick(1, 0, 0);
    chk("R5 first quick mark", int'(cf_mark), 1);
    tick(1, 600, 0);
    chk("R4 rearm under held peak", int'(cf_armed), 1);
    tick(1, 0, 0);
    chk("R5 second quick mark", int'(cf_mark), 1);
    gcount = 1;
    for (int i = 0; i < 6; i++) begin
      tick(0, 0, 0);
      if (gate_pulse) gcount++;
    end
    chk("R8 gate restarted by second mark", gcount, GLEN);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick(0, 0, 0);
    t_reset();
    t_basic_pulse();
    t_clear();
    t_noise();
    t_invalid();
    t_trim();
    t_retrigger();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule